// File: doc/BRIEF.md
# Host Memory Window Register Interface

This block is a sixteen-byte register file on a byte-wide host I/O port. Through it the host can read and write a 32-bit controller memory with no controller firmware in the loop. The host first loads a 16-bit window address register. That register holds a region bit, a dword offset and an access size code. The host then moves bytes through four data lanes. When the host touches the lane that completes the selected size, the block issues one transfer on a synchronous memory port with byte enables.

In the streaming size, each completed 32-bit access also steps the dword offset by one. This lets the host walk a whole region through the same four port addresses. The window also holds two one-byte mailboxes, one for each direction, and a 16-bit interrupt source/mask pair. It has a read-only identification byte fixed by a parameter. A host write to the inbound mailbox raises a controller interrupt. A source bit reaches the host interrupt line, and the host's view of the source register, only while its mask bit is set.

Top module: `hmw_regfile`

## Requirements
- R1: After reset every register reads 0, except offset 0xC, which reads the APP_ID parameter. No memory request, read-valid or controller interrupt is active while reset is asserted.
- R2: Offsets 0x2 and 0x3 are the low and high bytes of the window address, and both read back what was written. Address bit 15 is the region, bits 14:2 the dword offset and bits 1:0 the size code. mem_addr carries {region, offset}.
- R3: Size codes: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 32-bit streaming. The completing lane (data offset 0x4+lane) is lane 0, 1, 3 and 3 respectively. A host read of the completing lane issues one memory read in the strobe cycle. All four lanes are loaded from the returned word, and the read returns that word's byte for the lane read.
- R4: A host access to a data lane that does not complete the access issues no memory request. A read of such a lane returns the lane's held byte. No memory request occurs in a cycle without a host strobe.
- R5: A host write to the completing lane issues a memory write in the strobe cycle. The write data is the four lanes with the new byte merged in. Byte enables are 0001, 0011 or 1111 for the 8-, 16- and 32-bit sizes.
- R6: With size code 3, a completing read or write also advances the dword offset by one. This shows in the address readback, and the next completing access uses the new offset.
- R7: The offset wraps from 0x1FFF to 0. The region bit changes only when the host writes offset 0x3.
- R8: A host write to offset 0x0 stores the byte and drives ctrl_irq high for the one cycle after the strobe. Offset 0x1 holds the byte the controller loads via ctl_c2h_we. Host writes to 0x1 and 0xC have no effect.
- R9: ctl_src_set sets interrupt source bits. Host writes of ones to 0x8/0x9 clear source bits. Offsets 0xA/0xB are the read/write mask. Reads of 0x8/0x9 return source AND mask. host_irq is the OR of source AND mask, updated one cycle after the change.
- R10: Every host read returns its byte with host_rvalid high for exactly one cycle, two cycles after the read strobe. Offsets 0xD–0xF read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 4 | Host register offset |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_rdata | output | 8 | Host read byte |
| host_rvalid | output | 1 | host_rdata valid, two cycles after host_rd |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | 14 | {region, dword offset} |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Memory write word |
| mem_rdata | input | 32 | Memory read word, one cycle after a read request |
| ctl_c2h_we | input | 1 | Controller load of the outbound mailbox |
| ctl_c2h_data | input | 8 | Outbound mailbox byte |
| ctl_src_set | input | 16 | Controller sets interrupt source bits |
| ctrl_irq | output | 1 | Pulse to controller after an inbound mailbox write |
| host_irq | output | 1 | Masked interrupt to host |

## Verification
Memory requests are combinational from the host strobe, so the bench samples mem_req, mem_addr, mem_be and mem_wdata 1 ns after driving a strobe, inside the same cycle. The read byte and host_rvalid are due after the second rising edge following the read strobe. This allows one edge for the memory to answer and one for the output register, so the bench samples them at the next falling edge. Register state, the address step, ctrl_irq and host_irq each settle at the first edge after their stimulus. A reference model updated just after that edge is compared with host_irq and host_rvalid at every falling edge.

// File: rtl/hmw_pkg.sv
package hmw_pkg;

    localparam int OFS_W   = 13;
    localparam int MEM_AW  = OFS_W + 1;
    localparam int SRC_W   = 16;
    localparam int LANES   = 4;
    localparam int LANE_W  = $clog2(LANES);
    localparam int WORD_W  = 8 * LANES;

    typedef enum logic [1:0] {
        ACC_BYTE   = 2'd0,
        ACC_HALF   = 2'd1,
        ACC_WORD   = 2'd2,
        ACC_STREAM = 2'd3
    } acc_t;

    typedef enum logic [3:0] {
        RG_H2C    = 4'h0,
        RG_C2H    = 4'h1,
        RG_ADR_LO = 4'h2,
        RG_ADR_HI = 4'h3,
        RG_DAT0   = 4'h4,
        RG_DAT1   = 4'h5,
        RG_DAT2   = 4'h6,
        RG_DAT3   = 4'h7,
        RG_SRC_LO = 4'h8,
        RG_SRC_HI = 4'h9,
        RG_MSK_LO = 4'hA,
        RG_MSK_HI = 4'hB,
        RG_IDENT  = 4'hC
    } reg_t;

    typedef struct packed {
        logic             region;
        logic [OFS_W-1:0] ofs;
        acc_t             acc;
    } win_addr_t;

    typedef struct packed {
        logic              req;
        logic              we;
        logic [MEM_AW-1:0] addr;
        logic [LANES-1:0]  be;
        logic [WORD_W-1:0] wdata;
    } mem_cmd_t;

    // lane whose access completes a transfer of the given size
    function automatic logic [LANE_W-1:0] last_lane(acc_t a);
        case (a)
            ACC_BYTE: return LANE_W'(0);
            ACC_HALF: return LANE_W'(1);
            default:  return LANE_W'(LANES - 1);
        endcase
    endfunction

    function automatic logic [LANES-1:0] lane_mask(acc_t a);
        case (a)
            ACC_BYTE: return LANES'(4'b0001);
            ACC_HALF: return LANES'(4'b0011);
            default:  return '1;
        endcase
    endfunction

endpackage

// File: rtl/hmw_addr_reg.sv
module hmw_addr_reg
    import hmw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_lo,
    input  logic      wr_hi,
    input  logic [7:0] wdata,
    input  logic      bump,
    output win_addr_t addr_q
);

    logic [15:0] raw;
    assign raw = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= win_addr_t'(16'h0000);
        end else if (wr_lo) begin
            addr_q <= win_addr_t'({raw[15:8], wdata});
        end else if (wr_hi) begin
            addr_q <= win_addr_t'({wdata, raw[7:0]});
        end else if (bump) begin
            addr_q.ofs <= addr_q.ofs + 1'b1;
        end
    end

endmodule

// File: rtl/hmw_data_port.sv
module hmw_data_port
    import hmw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  win_addr_t         win,
    input  logic              rd_hit,
    input  logic              wr_hit,
    input  logic [LANE_W-1:0] lane,
    input  logic [7:0]        wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output mem_cmd_t          cmd,
    output logic              bump,
    output logic [WORD_W-1:0] buf_q,
    output logic              fetch_q
);

    logic              term;
    logic [WORD_W-1:0] merged;
    logic [7:0]        lane_q [LANES];

    always_comb begin
        term   = (lane == last_lane(win.acc));
        merged = buf_q;
        merged[{lane, 3'b000} +: 8] = wdata;

        cmd.req   = (rd_hit | wr_hit) & term;
        cmd.we    = wr_hit & term;
        cmd.addr  = {win.region, win.ofs};
        cmd.be    = wr_hit ? lane_mask(win.acc) : '1;
        cmd.wdata = merged;
        bump      = cmd.req && (win.acc == ACC_STREAM);
    end

    always_ff @(posedge clk) begin
        if (rst) fetch_q <= 1'b0;
        else     fetch_q <= rd_hit & term;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q[g] <= '0;
            end else if (fetch_q) begin
                lane_q[g] <= mem_rdata[g*8 +: 8];
            end else if (wr_hit && lane == LANE_W'(g)) begin
                lane_q[g] <= wdata;
            end
        end
        assign buf_q[g*8 +: 8] = lane_q[g];
    end

endmodule

// File: rtl/hmw_mbox_irq.sv
module hmw_mbox_irq
    import hmw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             h2c_we,
    input  logic [7:0]       wdata,
    input  logic             c2h_we,
    input  logic [7:0]       c2h_data,
    input  logic             clr_lo,
    input  logic             clr_hi,
    input  logic             msk_lo,
    input  logic             msk_hi,
    input  logic [SRC_W-1:0] src_set,
    output logic [7:0]       h2c_q,
    output logic [7:0]       c2h_q,
    output logic [SRC_W-1:0] src_vis,
    output logic [SRC_W-1:0] msk_q,
    output logic             ctrl_irq,
    output logic             host_irq
);

    logic [SRC_W-1:0] src_q;
    logic [SRC_W-1:0] clr;

    assign clr      = {clr_hi ? wdata : 8'h00, clr_lo ? wdata : 8'h00};
    assign src_vis  = src_q & msk_q;
    assign host_irq = |src_vis;

    always_ff @(posedge clk) begin
        if (rst) begin
            h2c_q    <= '0;
            c2h_q    <= '0;
            src_q    <= '0;
            msk_q    <= '0;
            ctrl_irq <= 1'b0;
        end else begin
            ctrl_irq <= h2c_we;
            if (h2c_we) h2c_q <= wdata;
            if (c2h_we) c2h_q <= c2h_data;
            src_q <= (src_q & ~clr) | src_set;
            if (msk_lo) msk_q[7:0]  <= wdata;
            if (msk_hi) msk_q[15:8] <= wdata;
        end
    end

endmodule

// File: rtl/hmw_regfile.sv
module hmw_regfile
    import hmw_pkg::*;
#(
    parameter logic [7:0] APP_ID = 8'h5C
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [3:0]                host_addr,
    input  logic                      host_wr,
    input  logic [7:0]                host_wdata,
    input  logic                      host_rd,
    output logic [7:0]                host_rdata,
    output logic                      host_rvalid,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [hmw_pkg::MEM_AW-1:0] mem_addr,
    output logic [3:0]                mem_be,
    output logic [31:0]               mem_wdata,
    input  logic [31:0]               mem_rdata,
    input  logic                      ctl_c2h_we,
    input  logic [7:0]                ctl_c2h_data,
    input  logic [15:0]               ctl_src_set,
    output logic                      ctrl_irq,
    output logic                      host_irq
);

    reg_t      sel;
    logic      is_data;
    win_addr_t win_q;
    mem_cmd_t  cmd;
    logic      bump;
    logic [WORD_W-1:0] buf_q;
    logic      fetch_q;
    logic [7:0]       h2c_q, c2h_q;
    logic [SRC_W-1:0] src_vis, msk_q;
    logic      rd_q;
    reg_t      raddr_q;
    logic [7:0] rbyte;
    logic [15:0] win_raw;

    assign sel     = reg_t'(host_addr);
    assign is_data = (host_addr[3:2] == 2'b01);
    assign win_raw = win_q;

    hmw_addr_reg u_addr (
        .clk    (clk),
        .rst    (rst),
        .wr_lo  (host_wr && sel == RG_ADR_LO),
        .wr_hi  (host_wr && sel == RG_ADR_HI),
        .wdata  (host_wdata),
        .bump   (bump),
        .addr_q (win_q)
    );

    hmw_data_port u_data (
        .clk       (clk),
        .rst       (rst),
        .win       (win_q),
        .rd_hit    (host_rd && is_data),
        .wr_hit    (host_wr && is_data),
        .lane      (host_addr[LANE_W-1:0]),
        .wdata     (host_wdata),
        .mem_rdata (mem_rdata),
        .cmd       (cmd),
        .bump      (bump),
        .buf_q     (buf_q),
        .fetch_q   (fetch_q)
    );

    hmw_mbox_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .h2c_we   (host_wr && sel == RG_H2C),
        .wdata    (host_wdata),
        .c2h_we   (ctl_c2h_we),
        .c2h_data (ctl_c2h_data),
        .clr_lo   (host_wr && sel == RG_SRC_LO),
        .clr_hi   (host_wr && sel == RG_SRC_HI),
        .msk_lo   (host_wr && sel == RG_MSK_LO),
        .msk_hi   (host_wr && sel == RG_MSK_HI),
        .src_set  (ctl_src_set),
        .h2c_q    (h2c_q),
        .c2h_q    (c2h_q),
        .src_vis  (src_vis),
        .msk_q    (msk_q),
        .ctrl_irq (ctrl_irq),
        .host_irq (host_irq)
    );

    assign mem_req   = cmd.req;
    assign mem_we    = cmd.we;
    assign mem_addr  = cmd.addr;
    assign mem_be    = cmd.be;
    assign mem_wdata = cmd.wdata;

    // read pipeline: strobe captured, then byte selected one cycle later
    always_comb begin
        rbyte = 8'h00;
        case (raddr_q)
            RG_H2C:    rbyte = h2c_q;
            RG_C2H:    rbyte = c2h_q;
            RG_ADR_LO: rbyte = win_raw[7:0];
            RG_ADR_HI: rbyte = win_raw[15:8];
            RG_DAT0, RG_DAT1, RG_DAT2, RG_DAT3:
                rbyte = fetch_q ? mem_rdata[{raddr_q[1:0], 3'b000} +: 8]
                                : buf_q[{raddr_q[1:0], 3'b000} +: 8];
            RG_SRC_LO: rbyte = src_vis[7:0];
            RG_SRC_HI: rbyte = src_vis[15:8];
            RG_MSK_LO: rbyte = msk_q[7:0];
            RG_MSK_HI: rbyte = msk_q[15:8];
            RG_IDENT:  rbyte = APP_ID;
            default:   rbyte = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q        <= 1'b0;
            raddr_q     <= RG_H2C;
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
        end else begin
            rd_q        <= host_rd;
            if (host_rd) raddr_q <= sel;
            host_rvalid <= rd_q;
            if (rd_q) host_rdata <= rbyte;
        end
    end

endmodule

// File: rtl/hmw_checker.sv
module hmw_checker (
    input logic       clk,
    input logic       rst,
    input logic [3:0] host_addr,
    input logic       host_wr,
    input logic       host_rd,
    input logic       host_rvalid,
    input logic       mem_req,
    input logic       mem_we,
    input logic [3:0] mem_be,
    input logic       ctrl_irq,
    input logic       region
);

    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst)             age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    AST_RVALID_DUE: assert property (@(posedge clk) disable iff (rst)
        host_rd |=> ##1 host_rvalid);                                         // R10

    AST_RVALID_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2 && host_rvalid) |-> $past(host_rd, 2));                  // R10

    AST_NO_IDLE_MEM: assert property (@(posedge clk) disable iff (rst)
        !(host_rd || host_wr) |-> !mem_req);                                  // R4

    AST_WR_BE_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_be == 4'b0001 || mem_be == 4'b0011 || mem_be == 4'b1111)); // R5

    AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !host_wr) |-> !mem_we);                                   // R3

    AST_CTRL_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1 && ctrl_irq) |-> $past(host_wr && host_addr == 4'h0));   // R8

    AST_REGION_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(host_wr && host_addr == 4'h3) |=> $stable(region));                 // R7

endmodule

bind hmw_regfile hmw_checker i_hmw_checker (
    .clk         (clk),
    .rst         (rst),
    .host_addr   (host_addr),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_rvalid (host_rvalid),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_be      (mem_be),
    .ctrl_irq    (ctrl_irq),
    .region      (win_raw[15])
);

// File: tb/test_hmw_regfile.sv
`timescale 1ns/1ps
module test_hmw_regfile;
    import hmw_pkg::*;

    localparam logic [7:0] APP = 8'hC7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_rdata;
    logic        host_rvalid;
    logic        mem_req, mem_we;
    logic [MEM_AW-1:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        ctl_c2h_we = 1'b0;
    logic [7:0]  ctl_c2h_data = '0;
    logic [15:0] ctl_src_set = '0;
    logic        ctrl_irq, host_irq;

    always #5 clk = ~clk;

    hmw_regfile #(.APP_ID(APP)) i_hmw_regfile (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .ctl_c2h_we(ctl_c2h_we), .ctl_c2h_data(ctl_c2h_data),
        .ctl_src_set(ctl_src_set), .ctrl_irq(ctrl_irq), .host_irq(host_irq)
    );

    // behavioural memory, one-cycle read latency
    logic [31:0] mem_m [0:(1<<MEM_AW)-1];
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem_m[mem_addr][b*8 +: 8] <= mem_wdata[b*8 +: 8];
            end else begin
                mem_rdata <= mem_m[mem_addr];
            end
        end
    end

    // reference model state
    logic [15:0] m_adr = '0;
    logic [31:0] m_buf = '0;
    logic [7:0]  m_h2c = '0, m_c2h = '0;
    logic [15:0] m_src = '0, m_msk = '0;
    logic        m_rdd = 1'b0, m_rv = 1'b0;
    logic        mon_on = 1'b0;
    int checks = 0;
    int errors = 0;

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", r, act, exp, $time);
        end
    endtask

    function automatic int term_lane(input logic [1:0] t);
        return (t == 2'd0) ? 0 : (t == 2'd1) ? 1 : 3;
    endfunction

    // rvalid pipeline of the model
    always @(posedge clk) begin
        m_rv  <= m_rdd;
        m_rdd <= host_rd && !rst;
    end

    // per-clock comparison
    always @(negedge clk) begin
        if (mon_on) begin
            chk("R9 host_irq", 32'(host_irq), 32'(|(m_src & m_msk)));
            chk("R10 host_rvalid", 32'(host_rvalid), 32'(m_rv));
        end
    end

    task automatic hw(input logic [3:0] a, input logic [7:0] d, input string r);
        logic        exp_req;
        logic [3:0]  be;
        logic [31:0] mrg;
        int          k;
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        k = int'(a) - 4;
        exp_req = (a >= 4'h4 && a <= 4'h7) && (k == term_lane(m_adr[1:0]));
        mrg = m_buf;
        if (a >= 4'h4 && a <= 4'h7) mrg[k*8 +: 8] = d;
        be = (m_adr[1:0] == 2'd0) ? 4'b0001 : (m_adr[1:0] == 2'd1) ? 4'b0011 : 4'b1111;
        #1;
        chk({r, " mem_req"}, 32'(mem_req), 32'(exp_req));
        if (exp_req) begin
            chk({r, " mem_we"}, 32'(mem_we), 32'd1);
            chk({r, " mem_be"}, 32'(mem_be), 32'(be));
            chk({r, " mem_addr"}, 32'(mem_addr), 32'({m_adr[15], m_adr[14:2]}));
            chk({r, " mem_wdata"}, mem_wdata, mrg);
        end
        @(posedge clk);
        #1;
        host_wr = 1'b0;
        chk("R8 ctrl_irq", 32'(ctrl_irq), 32'(a == 4'h0));
        case (a)
            4'h0: m_h2c = d;
            4'h2: m_adr[7:0] = d;
            4'h3: m_adr[15:8] = d;
            4'h4, 4'h5, 4'h6, 4'h7: begin
                m_buf = mrg;
                if (exp_req && m_adr[1:0] == 2'd3) m_adr[14:2] = m_adr[14:2] + 13'd1;
            end
            4'h8: m_src[7:0]  = m_src[7:0]  & ~d;
            4'h9: m_src[15:8] = m_src[15:8] & ~d;
            4'hA: m_msk[7:0]  = d;
            4'hB: m_msk[15:8] = d;
            default: ;
        endcase
    endtask

    task automatic hr(input logic [3:0] a, input string r);
        logic        exp_req;
        logic [31:0] w;
        logic [15:0] vis;
        logic [7:0]  exp;
        int          k;
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        k = int'(a) - 4;
        exp_req = (a >= 4'h4 && a <= 4'h7) && (k == term_lane(m_adr[1:0]));
        w = mem_m[{m_adr[15], m_adr[14:2]}];
        vis = m_src & m_msk;
        case (a)
            4'h0: exp = m_h2c;
            4'h1: exp = m_c2h;
            4'h2: exp = m_adr[7:0];
            4'h3: exp = m_adr[15:8];
            4'h4, 4'h5, 4'h6, 4'h7: exp = exp_req ? w[k*8 +: 8] : m_buf[k*8 +: 8];
            4'h8: exp = vis[7:0];
            4'h9: exp = vis[15:8];
            4'hA: exp = m_msk[7:0];
            4'hB: exp = m_msk[15:8];
            4'hC: exp = APP;
            default: exp = 8'h00;
        endcase
        #1;
        chk({r, " mem_req"}, 32'(mem_req), 32'(exp_req));
        if (exp_req) begin
            chk({r, " mem_we"}, 32'(mem_we), 32'd0);
            chk({r, " mem_addr"}, 32'(mem_addr), 32'({m_adr[15], m_adr[14:2]}));
        end
        @(posedge clk);
        #1;
        host_rd = 1'b0;
        if (exp_req) begin
            m_buf = w;
            if (m_adr[1:0] == 2'd3) m_adr[14:2] = m_adr[14:2] + 13'd1;
        end
        @(posedge clk);
        @(negedge clk);
        chk({r, " rvalid"}, 32'(host_rvalid), 32'd1);
        chk({r, " rdata"}, 32'(host_rdata), 32'(exp));
    endtask

    task automatic set_adr(input logic [15:0] v, input string r);
        hw(4'h2, v[7:0], r);
        hw(4'h3, v[15:8], r);
    endtask

    task automatic ctl_src(input logic [15:0] v);
        @(negedge clk);
        ctl_src_set = v;
        @(posedge clk);
        #1;
        ctl_src_set = '0;
        m_src = m_src | v;
    endtask

    task automatic ctl_mb(input logic [7:0] d);
        @(negedge clk);
        ctl_c2h_we = 1'b1; ctl_c2h_data = d;
        @(posedge clk);
        #1;
        ctl_c2h_we = 1'b0;
        m_c2h = d;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << MEM_AW); i++)
            mem_m[i] = (i * 32'h9E3779B1) + 32'h01234567;

        // R1: reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 mem_req in reset", 32'(mem_req), 32'd0);
        chk("R1 rvalid in reset", 32'(host_rvalid), 32'd0);
        chk("R1 ctrl_irq in reset", 32'(ctrl_irq), 32'd0);
        rst = 1'b0;
        mon_on = 1'b1;
        for (int a = 0; a < 16; a++) begin
            if (a == 7) continue;
            hr(4'(a), (a >= 13) ? "R10 unmapped read" : "R1 reset value");
        end

        // R2: address register
        set_adr(16'h9236, "R2");
        hr(4'h2, "R2 addr lo");
        hr(4'h3, "R2 addr hi");

        // R3/R4: 8-bit access at offset 5
        set_adr(16'h0014, "R3");
        hr(4'h4, "R3 byte fetch");
        hr(4'h5, "R4 byte held lane");
        // 16-bit access at offset 5
        set_adr(16'h0015, "R3");
        hr(4'h4, "R4 half held lane");
        hr(4'h5, "R3 half fetch");
        // 32-bit access at offset 7
        set_adr(16'h001E, "R3");
        hr(4'h7, "R3 word fetch");
        hr(4'h4, "R4 word lane0");
        hr(4'h5, "R4 word lane1");
        hr(4'h6, "R4 word lane2");

        // R5: writes
        set_adr(16'h0026, "R5");
        hw(4'h4, 8'h11, "R4 write lane0");
        hw(4'h5, 8'h22, "R4 write lane1");
        hw(4'h6, 8'h33, "R4 write lane2");
        hw(4'h7, 8'h44, "R5 word write");
        hr(4'h7, "R5 word readback");
        set_adr(16'h0028, "R5");
        hw(4'h4, 8'hAB, "R5 byte write");
        set_adr(16'h002A, "R5");
        hr(4'h7, "R5 byte readback");
        set_adr(16'h0029, "R5");
        hw(4'h5, 8'hCD, "R5 half write");
        set_adr(16'h002A, "R5");
        hr(4'h7, "R5 half readback");
        hr(4'h4, "R5 half readback lane0");

        // R6: streaming reads
        set_adr(16'h0043, "R6");
        for (int n = 0; n < 3; n++) begin
            hr(4'h7, "R6 stream fetch");
            hr(4'h4, "R6 stream lane0");
            hr(4'h5, "R6 stream lane1");
            hr(4'h6, "R6 stream lane2");
        end
        hr(4'h2, "R6 offset after stream");
        hr(4'h3, "R6 offset hi after stream");
        // streaming write then readback
        hw(4'h4, 8'h5A, "R6 stream wr");
        hw(4'h5, 8'h6B, "R6 stream wr");
        hw(4'h6, 8'h7C, "R6 stream wr");
        hw(4'h7, 8'h8D, "R6 stream write");
        set_adr(16'h004F, "R6");
        hr(4'h7, "R6 stream write readback");

        // R7: wrap
        set_adr(16'hFFFF, "R7");
        hr(4'h7, "R7 wrap fetch");
        hr(4'h2, "R7 wrapped lo");
        hr(4'h3, "R7 region kept");
        set_adr(16'h7FFF, "R7");
        hw(4'h7, 8'h99, "R7 wrap write region0");
        hr(4'h3, "R7 region0 kept");
        hr(4'h2, "R7 wrapped lo region0");

        // R8: mailboxes and identification byte
        hw(4'h0, 8'hA5, "R8 h2c write");
        hr(4'h0, "R8 h2c read");
        ctl_mb(8'h3C);
        hr(4'h1, "R8 c2h read");
        hw(4'h1, 8'hFF, "R8 c2h host write");
        hr(4'h1, "R8 c2h unchanged");
        hw(4'hC, 8'h00, "R8 ident write");
        hr(4'hC, "R8 ident unchanged");

        // R9: interrupts
        ctl_src(16'h0102);
        hr(4'h8, "R9 masked src lo");
        hw(4'hA, 8'h02, "R9 mask lo");
        hr(4'h8, "R9 visible src lo");
        hr(4'hA, "R9 mask lo read");
        hw(4'hB, 8'h01, "R9 mask hi");
        hr(4'h9, "R9 visible src hi");
        hw(4'h8, 8'h02, "R9 clear lo");
        hr(4'h8, "R9 cleared lo");
        hw(4'h9, 8'h01, "R9 clear hi");
        hr(4'h9, "R9 cleared hi");
        ctl_src(16'h0002);
        hr(4'h8, "R9 set again");

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule